// File: doc/BRIEF.md
# Mode-Controlled One-Hot Scroller

This block drives a four-position one-hot pattern. A single active bit either walks toward the most significant position, walks toward the least significant position, or stays where it is. The choice depends on a registered scroll mode. The pattern moves only on cycles where a sparse, single-cycle advance strobe is high. Each move wraps at the ends, so the active bit circulates through all positions.

Three active-high command inputs (halt, rise, fall) choose the mode. They are sampled on every clock edge whatever the strobe is doing, and a fixed priority settles any conflict between them. On each edge, the pattern moves according to the mode that was held before that edge. A command arriving on the same edge only affects later advances. The mode register is also brought out as an output, so the pattern and the mode can be checked together against a reference model on every cycle.

Top module: `onehot_scroller`

## Requirements
- R1: A synchronous active-high `rst` forces `pattern_o` to 4'b0001 and `mode_o` to 0 on the next edge. Reset overrides `adv_i` and all commands on that edge. The same values apply at power-up.
- R2: `mode_o` encodes the mode as follows: 0 means halt, 1 means rise, 2 means fall.
- R3: While `adv_i` is low, `pattern_o` keeps its value in every mode.
- R4: In rise mode (1), an edge with `adv_i` high moves the active bit one position toward bit 3. From bit 3 it wraps to bit 0, as in 0100→1000→0001.
- R5: In fall mode (2), an edge with `adv_i` high moves the active bit one position toward bit 0. From bit 0 it wraps to bit 3, as in 0010→0001→1000.
- R6: In halt mode (0), an edge with `adv_i` high leaves `pattern_o` unchanged.
- R7: A command changes `mode_o` on the next edge, whatever the value of `adv_i`. Every mode can be reached from every other mode. With no command asserted, the mode is held.
- R8: When several commands are high in one cycle, `cmd_halt_i` wins over `cmd_rise_i`, and `cmd_rise_i` wins over `cmd_fall_i`.
- R9: The move applied on an edge uses the mode held before that edge, not the mode a command on that edge selects.
- R10: `pattern_o` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Single-cycle advance strobe |
| cmd_halt_i | input | 1 | Command: enter halt mode |
| cmd_rise_i | input | 1 | Command: enter rise mode |
| cmd_fall_i | input | 1 | Command: enter fall mode |
| pattern_o | output | 4 | Registered one-hot pattern |
| mode_o | output | 2 | Registered mode (0 halt, 1 rise, 2 fall) |

## Verification
The bench targets the wrap points at both ends, because a shift without wrap would empty the pattern to zero. It pairs a strobe with a mode change on the same edge, where a design that rotates using the newly selected mode would move one step too early or in the wrong direction. It drives every combination of commands at once, which exposes a wrong priority as a mode value off by one. It also asserts reset together with the strobe and commands, which catches a reset that lets the pattern move. A long random walk against a cycle model then mixes all of these cases.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_HALT = 2'd0,
    MODE_RISE = 2'd1,
    MODE_FALL = 2'd2
  } scroll_mode_e;
endpackage

// File: rtl/scroll_mode_fsm.sv
module scroll_mode_fsm
  import scroll_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_halt_i,
  input  logic         cmd_rise_i,
  input  logic         cmd_fall_i,
  output scroll_mode_e mode_o
);
  scroll_mode_e mode_q = MODE_HALT;
  scroll_mode_e mode_d;

  // priority: halt > rise > fall; an unknown encoding falls back to halt
  always_comb begin
    if (cmd_halt_i)      mode_d = MODE_HALT;
    else if (cmd_rise_i) mode_d = MODE_RISE;
    else if (cmd_fall_i) mode_d = MODE_FALL;
    else begin
      case (mode_q)
        MODE_HALT, MODE_RISE, MODE_FALL: mode_d = mode_q;
        default:                         mode_d = MODE_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_HALT;
    else     mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/scroll_rotator.sv
module scroll_rotator
  import scroll_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  scroll_mode_e     mode_i,
  output logic [WIDTH-1:0] pat_o
);
  localparam logic [WIDTH-1:0] RESET_PAT = WIDTH'(1);

  logic [WIDTH-1:0] pat_q = RESET_PAT;
  logic [WIDTH-1:0] pat_up;
  logic [WIDTH-1:0] pat_dn;
  logic [WIDTH-1:0] pat_d;

  // one-position circular neighbours in each direction
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pat_up[i] = pat_q[(i + WIDTH - 1) % WIDTH];
    assign pat_dn[i] = pat_q[(i + 1) % WIDTH];
  end

  always_comb begin
    pat_d = pat_q;
    if (adv_i) begin
      case (mode_i)
        MODE_RISE: pat_d = pat_up;
        MODE_FALL: pat_d = pat_dn;
        default:   pat_d = pat_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pat_q <= RESET_PAT;
    else     pat_q <= pat_d;
  end

  assign pat_o = pat_q;
endmodule

// File: rtl/onehot_scroller.sv
module onehot_scroller
  import scroll_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  input  logic              cmd_halt_i,
  input  logic              cmd_rise_i,
  input  logic              cmd_fall_i,
  output logic [WIDTH-1:0]  pattern_o,
  output logic [MODE_W-1:0] mode_o
);
  scroll_mode_e mode_cur;

  scroll_mode_fsm u_mode (
    .clk        (clk),
    .rst        (rst),
    .cmd_halt_i (cmd_halt_i),
    .cmd_rise_i (cmd_rise_i),
    .cmd_fall_i (cmd_fall_i),
    .mode_o     (mode_cur)
  );

  // rotator sees the pre-edge mode, so a same-edge command cannot steer it
  scroll_rotator #(.WIDTH(WIDTH)) u_rot (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (adv_i),
    .mode_i (mode_cur),
    .pat_o  (pattern_o)
  );

  assign mode_o = mode_cur;
endmodule

// File: rtl/scroller_chk.sv
module scroller_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             adv_i,
  input logic             cmd_halt_i,
  input logic             cmd_rise_i,
  input logic             cmd_fall_i,
  input logic [WIDTH-1:0] pattern_o,
  input logic [1:0]       mode_o
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pattern_o == WIDTH'(1) && mode_o == 2'd0));

  p_legal_mode_r2: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(pattern_o));

  p_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_i && mode_o == 2'd1) |=>
      pattern_o == {$past(pattern_o[WIDTH-2:0]), $past(pattern_o[WIDTH-1])});

  p_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (adv_i && mode_o == 2'd2) |=>
      pattern_o == {$past(pattern_o[0]), $past(pattern_o[WIDTH-1:1])});

  p_halt_r6: assert property (@(posedge clk) disable iff (rst)
    (adv_i && mode_o == 2'd0) |=> $stable(pattern_o));

  p_keep_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (!cmd_halt_i && !cmd_rise_i && !cmd_fall_i) |=> $stable(mode_o));

  p_halt_wins_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_halt_i |=> mode_o == 2'd0);

  p_rise_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (!cmd_halt_i && cmd_rise_i) |=> mode_o == 2'd1);

  p_fall_only_r8: assert property (@(posedge clk) disable iff (rst)
    (!cmd_halt_i && !cmd_rise_i && cmd_fall_i) |=> mode_o == 2'd2);

  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(pattern_o) == 1);
endmodule

bind onehot_scroller scroller_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .adv_i      (adv_i),
  .cmd_halt_i (cmd_halt_i),
  .cmd_rise_i (cmd_rise_i),
  .cmd_fall_i (cmd_fall_i),
  .pattern_o  (pattern_o),
  .mode_o     (mode_o)
);

// File: tb/sim_onehot_scroller.sv
module sim_onehot_scroller;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv = 1'b0;
  logic       c_halt = 1'b0;
  logic       c_rise = 1'b0;
  logic       c_fall = 1'b0;
  logic [3:0] pat;
  logic [1:0] mode;

  always #2.5 clk = ~clk;

  onehot_scroller u0 (
    .clk(clk), .rst(rst), .adv_i(adv),
    .cmd_halt_i(c_halt), .cmd_rise_i(c_rise), .cmd_fall_i(c_fall),
    .pattern_o(pat), .mode_o(mode)
  );

  typedef struct {
    logic [3:0] q;
    logic [1:0] m;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 0;
  logic [3:0] m_q = 4'b0001;
  logic [1:0] m_mode = 2'd0;

  // driver: apply one cycle of stimulus and queue the predicted result
  task automatic drive(input logic r, input logic e, input logic h,
                       input logic u, input logic d, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; adv = e; c_halt = h; c_rise = u; c_fall = d;
    if (r) begin
      m_q = 4'b0001; m_mode = 2'd0;
    end else begin
      if (e && m_mode == 2'd1) m_q = {m_q[2:0], m_q[3]};
      else if (e && m_mode == 2'd2) m_q = {m_q[0], m_q[3:1]};
      if (h)      m_mode = 2'd0;
      else if (u) m_mode = 2'd1;
      else if (d) m_mode = 2'd2;
    end
    x.q = m_q; x.m = m_mode; x.tag = tag;
    sb.push_back(x);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        n_vec++;
        if (pat !== x.q || mode !== x.m) begin
          n_bad++;
          $display("FAIL %s: pattern=%b mode=%0d expected pattern=%b mode=%0d",
                   x.tag, pat, mode, x.q, x.m);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset while strobe and all commands are high
    drive(1, 1, 1, 1, 1, "R1");
    drive(1, 1, 0, 1, 0, "R1");
    // R7 / R2: rise command with strobe low -> mode 1, pattern unmoved
    drive(0, 0, 0, 1, 0, "R7");
    // R4: four rise advances, wrap 1000 -> 0001
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 0, "R4");
    // R3: strobe low holds pattern in rise mode
    drive(0, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, "R3");
    // R9: fall command with strobe on same edge -> still rotates up
    drive(0, 1, 0, 0, 1, "R9");
    // R5: fall advances, wrapping 0001 -> 1000
    for (int i = 0; i < 5; i++) drive(0, 1, 0, 0, 0, "R5");
    // R9: halt with strobe -> last fall step still applied
    drive(0, 1, 1, 0, 0, "R9");
    // R6: halt mode ignores strobe
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, 0, "R6");
    // R8: priority across all command combinations
    drive(0, 0, 0, 1, 1, "R8");
    drive(0, 0, 1, 1, 0, "R8");
    drive(0, 0, 0, 0, 1, "R8");
    drive(0, 0, 1, 0, 1, "R8");
    drive(0, 0, 0, 1, 1, "R8");
    drive(0, 0, 1, 1, 1, "R8");
    drive(0, 0, 0, 0, 1, "R7");
    drive(0, 0, 0, 0, 0, "R7");
    // R1: reset in fall mode mid-pattern
    drive(0, 1, 0, 0, 0, "R5");
    drive(1, 1, 0, 0, 1, "R1");
    // R10 and mixed: random walk against the model
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 64) == 0, ($urandom % 4) == 0,
            ($urandom % 8) == 0, ($urandom % 8) == 0,
            ($urandom % 8) == 0, "R10");
    end
    drive(0, 0, 0, 0, 0, "R3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule